// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the byte-wide bus writes that land in one 64 KiB bank, the flash I/O window. Writes to three fixed offsets in that bank are shifted into a command history register. The block looks in that history for short unlock-and-command sequences. One sequence switches on identification reads. One switches on array programming. One brings back write protection, and one switches everything off. The flash array itself lives outside the block. The block only drives mode flags, a strobe that tells the array to take a byte directly, and a one-cycle request to rebuild the memory map.

On the read side, the block sits between the array's read data and the bus. While the modes are active, it replaces array data at a few offsets. Two offsets return a fixed status byte. A small even-offset region near the top of the bank returns a manufacturer and device identification table.

Writing the same full address twice in a row while programming is enabled counts as a data write. That write goes straight to the array, and the decoder does not see it as a command byte.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, flash_en, write_en, read_en and remap_req are 0, the history is empty and no previous address is held. A read in the window returns array_rdata.
- R2: A window write at offset 0x0000, 0x2AAA or 0x5555 shifts its data byte into the low byte of a 24-bit history. When a write at 0x0000 leaves the low 16 history bits at 0x38D0, flash_en and read_en are 1 from the next cycle.
- R3: When a write at 0x5555 leaves the low 24 history bits at 0xAA55F0, flash_en, write_en and read_en are all 0 from the next cycle.
- R4: When a write at 0x5555 leaves 0xAA55A0 in the history, flash_en and write_en are set and the stored previous address is cleared. A write that follows, to the same address as the one before it, is then not a direct write.
- R5: When a write at 0x5555 leaves 0xAA5570 in the history, only write_en is cleared. flash_en and read_en keep their values.
- R6: When a write at 0x5555 leaves 0xAA5580 or 0xAA5510 in the history, none of the flags change.
- R7: Window writes at other offsets do not shift the history. Writes outside bank 0xC0 (bus_addr[23:16]) are ignored completely.
- R8: When write_en is 1, a window write whose full 24-bit address equals the previous window write's address raises bypass_wr in that same cycle. That write does not shift the history and does not decode a command.
- R9: A window read at offset 0x0002 or 0x5555 returns 0x80 while flash_en is 1. Otherwise it returns array_rdata.
- R10: While read_en is 1, window reads at even offsets from 0xFF00 to 0xFF12 return an identification byte taken from the offset's low 5 bits: 0x4D at 0x00, 0x50 at 0x02, 0x2B at 0x06, and 0x00 at every other even offset. Odd offsets, and offsets outside that range, return array_rdata.
- R11: remap_req is 1 for exactly the one cycle after a command changes write_en, and 0 at all other times.
- R12: While write_en is 0, a repeated write to the same address raises no bypass_wr and is decoded as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 24 | Bus address: bank in [23:16], offset in [15:0] |
| bus_wdata | input | 8 | Write data byte |
| array_rdata | input | 8 | Read data from the external flash array |
| bus_rdata | output | 8 | Read data returned to the bus |
| flash_en | output | 1 | Command mode active (status reads enabled) |
| write_en | output | 1 | Array programming enabled |
| read_en | output | 1 | Identification reads enabled |
| bypass_wr | output | 1 | Direct array write of bus_wdata at bus_addr this cycle |
| remap_req | output | 1 | One-cycle request to rebuild the memory map |

## Verification
If the history is wrong, the wrong flag shows up one cycle after the final byte of a sequence. It also shows up on the next read at 0x0002, 0x5555 or the identification region. That read is combinational, so it is visible in the same cycle the read is made. If the stored previous address is wrong, bypass_wr is wrong in the very cycle of the next window write. A bypassed write that still shifted the history shows up only later, as a sequence that fires or fails when it should not. The bench therefore places bypassed writes inside command sequences, and compares every output against a behavioural model on every clock.

// File: rtl/fcd_pkg.sv
// Shared constants, offset classes and the identification table of the
// flash command decoder. Assumes a 16-bit offset inside the window bank.
package fcd_pkg;

    localparam int OFS_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OFS_OTHER = 2'd0,
        OFS_IDENT = 2'd1,   // 0x0000: identification sequence ends here
        OFS_UNLK  = 2'd2,   // 0x2AAA: unlock byte only
        OFS_CMD   = 2'd3    // 0x5555: command sequences end here
    } ofs_kind_e;

    localparam logic [OFS_W-1:0] OFS_IDENT_A = 16'h0000;
    localparam logic [OFS_W-1:0] OFS_UNLK_A  = 16'h2AAA;
    localparam logic [OFS_W-1:0] OFS_CMD_A   = 16'h5555;
    localparam logic [OFS_W-1:0] OFS_STATUS  = 16'h0002;
    localparam logic [OFS_W-1:0] OFS_ID_LO   = 16'hFF00;
    localparam logic [OFS_W-1:0] OFS_ID_HI   = 16'hFF12;

    localparam logic [BYTE_W-1:0] STATUS_BYTE = 8'h80;

    localparam logic [15:0] SEQ_IDENT = 16'h38D0;
    localparam logic [23:0] SEQ_OFF   = 24'hAA55F0;
    localparam logic [23:0] SEQ_WREN  = 24'hAA55A0;
    localparam logic [23:0] SEQ_PROT  = 24'hAA5570;

    // Map an offset to the role it plays in the command history.
    function automatic ofs_kind_e classify(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_IDENT_A: classify = OFS_IDENT;
            OFS_UNLK_A:  classify = OFS_UNLK;
            OFS_CMD_A:   classify = OFS_CMD;
            default:     classify = OFS_OTHER;
        endcase
    endfunction

    // Identification byte for an index taken from the offset's low bits.
    function automatic logic [BYTE_W-1:0] id_byte(input logic [4:0] idx);
        case (idx)
            5'h00:   id_byte = 8'h4D;
            5'h02:   id_byte = 8'h50;
            5'h06:   id_byte = 8'h2B;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/fcd_history.sv
// Command history shift register. Shifts a byte in from the low end when
// shift_en is high. It also exposes the value the history will hold after
// the shift, so the decode can act on the same cycle's byte.
module fcd_history #(
    parameter int HIST_BYTES = 3,
    localparam int HIST_W = HIST_BYTES * fcd_pkg::BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [fcd_pkg::BYTE_W-1:0]  din,
    output logic [HIST_W-1:0]           hist_q,
    output logic [HIST_W-1:0]           hist_next
);

    // Candidate value: the current history with the new byte appended.
    always_comb begin
        hist_next = {hist_q[HIST_W-fcd_pkg::BYTE_W-1:0], din};
    end

    // Hold or shift the history; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (shift_en)
            hist_q <= hist_next;
    end

endmodule

// File: rtl/fcd_ctrl.sv
// Mode flags, previous-write address and bypass detection. Assumes that
// win_wr is already limited to writes inside the window bank, and that the
// history holds at least three bytes.
module fcd_ctrl #(
    parameter int ADDR_W = 24,
    parameter int HIST_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [HIST_W-1:0]   hist_next,
    output logic                shift_en,
    output logic                bypass,
    output logic                flash_en,
    output logic                write_en,
    output logic                read_en,
    output logic                remap_req
);
    import fcd_pkg::*;

    logic [ADDR_W-1:0] prev_q, prev_d;
    logic fe_d, we_d, re_d, clr_prev;
    ofs_kind_e kind;

    // Classify the offset and find a repeated address while writes are enabled.
    always_comb begin
        kind     = classify(addr[OFS_W-1:0]);
        bypass   = win_wr && (addr == prev_q) && write_en;
        shift_en = win_wr && !bypass && (kind != OFS_OTHER);
    end

    // Decode a finished sequence from the history value after this write.
    always_comb begin
        fe_d     = flash_en;
        we_d     = write_en;
        re_d     = read_en;
        clr_prev = 1'b0;
        if (shift_en) begin
            if (kind == OFS_IDENT) begin
                if (hist_next[15:0] == SEQ_IDENT) begin
                    fe_d = 1'b1;
                    re_d = 1'b1;
                end
            end else if (kind == OFS_CMD) begin
                case (hist_next[23:0])
                    SEQ_OFF: begin
                        fe_d = 1'b0;
                        we_d = 1'b0;
                        re_d = 1'b0;
                    end
                    SEQ_WREN: begin
                        fe_d     = 1'b1;
                        we_d     = 1'b1;
                        clr_prev = 1'b1;
                    end
                    SEQ_PROT: we_d = 1'b0;
                    default: ;  // 0xAA5580 and 0xAA5510 also end up here
                endcase
            end
        end
        prev_d = win_wr ? (clr_prev ? '0 : addr) : prev_q;
    end

    // Register the flags, the previous address and the remap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_en  <= 1'b0;
            write_en  <= 1'b0;
            read_en   <= 1'b0;
            prev_q    <= '0;
            remap_req <= 1'b0;
        end else begin
            flash_en  <= fe_d;
            write_en  <= we_d;
            read_en   <= re_d;
            prev_q    <= prev_d;
            remap_req <= (we_d != write_en);
        end
    end

    // R2: identification mode never stays on once command mode is off
    a_r2_read_implies_flash: assert property (@(posedge clk) disable iff (!rst_n)
        read_en |-> flash_en);

    // R4: programming is only possible while command mode is on
    a_r4_write_implies_flash: assert property (@(posedge clk) disable iff (!rst_n)
        write_en |-> flash_en);

    // R11: every change of write_en is announced in the cycle it appears
    a_r11_remap_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (write_en != $past(write_en)) |-> remap_req);

endmodule

// File: rtl/fcd_readmux.sv
// Read-data selector. Status and identification bytes replace array data
// inside the window while their modes are on. Purely combinational.
module fcd_readmux (
    input  logic                        in_win,
    input  logic [fcd_pkg::OFS_W-1:0]   ofs,
    input  logic                        flash_en,
    input  logic                        read_en,
    input  logic [fcd_pkg::BYTE_W-1:0]  array_rdata,
    output logic [fcd_pkg::BYTE_W-1:0]  rdata
);
    import fcd_pkg::*;

    logic is_status, is_id;

    // Pick status, identification or array data for this offset.
    always_comb begin
        is_status = (ofs == OFS_STATUS) || (ofs == OFS_CMD_A);
        is_id     = (ofs >= OFS_ID_LO) && (ofs <= OFS_ID_HI) && !ofs[0];
        rdata     = array_rdata;
        if (in_win) begin
            if (flash_en && is_status)
                rdata = STATUS_BYTE;
            else if (read_en && is_id)
                rdata = id_byte(ofs[4:0]);
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder. Picks out the window bank, shifts
// command bytes into the history, and drives the mode flags, the bypass
// strobe and the read substitution. Assumes one bus access per cycle.
module flash_cmd_decoder #(
    parameter int          ADDR_W     = 24,
    parameter int          HIST_BYTES = 3,
    parameter logic [7:0]  WIN_BANK   = 8'hC0,
    localparam int         HIST_W     = HIST_BYTES * fcd_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        array_rdata,
    output logic [7:0]        bus_rdata,
    output logic              flash_en,
    output logic              write_en,
    output logic              read_en,
    output logic              bypass_wr,
    output logic              remap_req
);

    logic in_win, win_wr, shift_en;
    logic [HIST_W-1:0] hist_q, hist_next;

    // Window hit and the write strobe limited to the window.
    always_comb begin
        in_win = (bus_addr[ADDR_W-1:fcd_pkg::OFS_W] == WIN_BANK);
        win_wr = bus_wr && in_win;
    end

    fcd_history #(.HIST_BYTES(HIST_BYTES)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (bus_wdata),
        .hist_q    (hist_q),
        .hist_next (hist_next)
    );

    fcd_ctrl #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_wr    (win_wr),
        .addr      (bus_addr),
        .hist_next (hist_next),
        .shift_en  (shift_en),
        .bypass    (bypass_wr),
        .flash_en  (flash_en),
        .write_en  (write_en),
        .read_en   (read_en),
        .remap_req (remap_req)
    );

    fcd_readmux u_rmux (
        .in_win      (in_win),
        .ofs         (bus_addr[fcd_pkg::OFS_W-1:0]),
        .flash_en    (flash_en),
        .read_en     (read_en),
        .array_rdata (array_rdata),
        .rdata       (bus_rdata)
    );

    // R8: a direct array write leaves the command history untouched
    a_r8_bypass_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_wr |=> $stable(hist_q));

    // R7: a write outside the window never moves the history
    a_r7_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_win) |=> $stable(hist_q));

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  array_rdata = '0;
    logic [7:0]  bus_rdata;
    logic        flash_en, write_en, read_en, bypass_wr, remap_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Behavioural reference state
    int unsigned m_hist = 0;
    int unsigned m_prev = 0;
    bit m_fe = 0, m_we = 0, m_re = 0, m_remap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .array_rdata(array_rdata), .bus_rdata(bus_rdata),
        .flash_en(flash_en), .write_en(write_en), .read_en(read_en),
        .bypass_wr(bypass_wr), .remap_req(remap_req)
    );

    function automatic logic [7:0] arr_of(input logic [23:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] exp_read(input logic [23:0] a);
        int unsigned o = a[15:0];
        logic [7:0] r = arr_of(a);
        if (a[23:16] == 8'hC0) begin
            if (m_fe && (o == 'h0002 || o == 'h5555)) r = 8'h80;
            else if (m_re && o >= 'hFF00 && o <= 'hFF12 && (o % 2) == 0) begin
                if (o == 'hFF00) r = 8'h4D;
                else if (o == 'hFF02) r = 8'h50;
                else if (o == 'hFF06) r = 8'h2B;
                else r = 8'h00;
            end
        end
        return r;
    endfunction

    // One bus cycle: drive, compare all outputs, then advance the model.
    task automatic step(input bit wr, input logic [23:0] a, input logic [7:0] d, input string tag);
        logic [12:0] act, exp;
        bit byp, old_we;
        int unsigned o;
        bus_wr = wr; bus_addr = a; bus_wdata = d; array_rdata = arr_of(a);
        #1;
        o = a[15:0];
        byp = wr && (a[23:16] == 8'hC0) && (a == m_prev) && m_we;
        act = {flash_en, write_en, read_en, remap_req, bypass_wr, bus_rdata};
        exp = {m_fe, m_we, m_re, m_remap, byp, exp_read(a)};
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%06h actual=%04h expected=%04h", tag, a, act, exp);
        end
        @(posedge clk);
        old_we = m_we;
        if (wr && a[23:16] == 8'hC0) begin
            m_prev = a;
            if (!byp && (o == 'h0000 || o == 'h2AAA || o == 'h5555)) begin
                m_hist = ((m_hist << 8) | d) & 'hFFFFFF;
                if (o == 'h0000 && (m_hist & 'hFFFF) == 'h38D0) begin
                    m_fe = 1; m_re = 1;
                end
                if (o == 'h5555) begin
                    if (m_hist == 'hAA55F0) begin m_fe = 0; m_we = 0; m_re = 0; end
                    else if (m_hist == 'hAA55A0) begin m_fe = 1; m_we = 1; m_prev = 0; end
                    else if (m_hist == 'hAA5570) m_we = 0;
                end
            end
        end
        m_remap = (old_we != m_we);
        @(negedge clk);
    endtask

    task automatic wr(input logic [23:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [23:0] a, input string tag);
        step(1'b0, a, 8'h00, tag);
    endtask

    task automatic seq(input logic [7:0] c, input string tag);
        wr(24'hC05555, 8'hAA, tag);
        wr(24'hC02AAA, 8'h55, tag);
        wr(24'hC05555, c, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(24'hC00002, "R1");
        rd(24'hC05555, "R9");
        rd(24'hC0FF00, "R10");
        // R2: identification sequence
        wr(24'hC00000, 8'h38, "R2");
        wr(24'hC00000, 8'hD0, "R12");
        rd(24'hC00002, "R9");
        rd(24'hC05555, "R9");
        rd(24'hC0FF00, "R10");
        rd(24'hC0FF02, "R10");
        rd(24'hC0FF06, "R10");
        rd(24'hC0FF04, "R10");
        rd(24'hC0FF12, "R10");
        rd(24'hC0FF01, "R10");
        rd(24'hC0FF14, "R10");
        rd(24'h80FF00, "R10");
        rd(24'hC01234, "R9");
        // R3: everything off
        seq(8'hF0, "R3");
        rd(24'hC05555, "R3");
        rd(24'hC0FF00, "R3");
        // R7: other offsets and other banks do not disturb the sequence
        wr(24'hC00000, 8'h38, "R7");
        wr(24'hC01234, 8'h77, "R7");
        wr(24'h400000, 8'hD0, "R7");
        wr(24'hC00000, 8'hD0, "R7");
        rd(24'hC0FF02, "R7");
        // R6: accepted but inert commands
        seq(8'h80, "R6");
        seq(8'h10, "R6");
        rd(24'hC05555, "R6");
        // R4, R11: enable programming
        seq(8'hA0, "R4");
        rd(24'hC00002, "R11");
        // R4: previous address was cleared, so no bypass here
        wr(24'hC05555, 8'hAA, "R4");
        wr(24'hC02AAA, 8'h55, "R8");
        wr(24'hC02AAA, 8'hF0, "R8");
        // R5: protect lands with history AA,55,70 (bypassed byte skipped)
        wr(24'hC05555, 8'h70, "R5");
        rd(24'hC0FF00, "R5");
        rd(24'hC00002, "R11");
        // R12: repeated address with programming off
        wr(24'hC01000, 8'h11, "R12");
        wr(24'hC01000, 8'h22, "R12");
        // R8: direct writes while programming is enabled
        seq(8'hA0, "R8");
        wr(24'hC01000, 8'h11, "R8");
        wr(24'hC01000, 8'h22, "R8");
        wr(24'hC01000, 8'h33, "R8");
        wr(24'hC11000, 8'h44, "R8");
        wr(24'hC11000, 8'h55, "R8");
        // R3: off clears programming too, remap pulse follows
        seq(8'hF0, "R3");
        rd(24'hC05555, "R11");
        rd(24'hC05555, "R11");
        // R1: reset in the middle of a mode
        wr(24'hC00000, 8'h38, "R1");
        wr(24'hC00000, 8'hD0, "R1");
        rst_n = 1'b0;
        @(posedge clk);
        m_fe = 0; m_we = 0; m_re = 0; m_remap = 0; m_hist = 0; m_prev = 0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(24'hC00002, "R1");
        wr(24'hC00000, 8'hD0, "R1");
        rd(24'hC0FF00, "R1");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule